// File: doc/BRIEF.md
# Transmit Enable Watchdog and Bus Drive Gating

This block sits between the communication controller's transmit pins (an active-low enable and a data bit) and the line-driver controls of a bus transceiver. On every clock it decides whether the differential driver is switched active, and which data level it carries, or whether the bus is left idle. A driver that stays idle while the enable is high, and follows the data while the enable is low, is the normal case.

A watchdog counts how long the enable has been held low without a break. When a controller keeps the enable low for longer than a programmable time, which is milliseconds in a real system, the block treats it as a runaway transmitter. It forces the driver idle, raises a fault level for the diagnostic register block, and emits a one-cycle event for the interrupt logic. The lockout ends only when the enable goes high again. Overtemperature, low core or I/O supply, and the low-power standby mode each also hold the driver idle. These conditions do not pause the watchdog.

The timeout is given in microseconds together with the clock frequency, and the cycle count is derived from them.

Top module: `tx_gate_guard`

## Requirements
- R1: One clock edge after `tx_en_n` is sampled high, `drive_active` is 0.
- R2: When `tx_en_n` is sampled low, no lockout is in force, `mode_normal`=1, `otemp`=0, `vcc_ok`=1 and `vio_ok`=1, the next edge sets `drive_active`=1 and `drive_data` equal to the sampled `tx_data`.
- R3: `drive_data` is 0 in every cycle in which `drive_active` is 0.
- R4: On the edge that samples `tx_en_n` low for the TIMEOUT_CYC-th consecutive time, `stuck_flag` goes to 1 and `drive_active` goes to 0. TIMEOUT_CYC = CLK_HZ*TIMEOUT_US/1e6. A run that is one sample shorter does not trip.
- R5: `stuck_pulse` is high for exactly the one cycle in which `stuck_flag` rises, and at no other time.
- R6: While `tx_en_n` stays low, `stuck_flag` stays 1 and the driver stays idle. The first edge that samples `tx_en_n` high clears `stuck_flag` and the run count. A new low enable then transmits again, and the timeout is counted afresh from zero.
- R7: `otemp`=1 sampled at an edge makes `drive_active` 0 after that edge.
- R8: `vcc_ok`=0 or `vio_ok`=0 sampled at an edge makes `drive_active` 0 after that edge.
- R9: `mode_normal`=0 (standby) sampled at an edge makes `drive_active` 0 after that edge.
- R10: The watchdog keeps counting a low enable while any of the R7 to R9 idle conditions holds, so it can trip during them.
- R11: While `rst_n` is low, `drive_active`, `drive_data`, `stuck_flag` and `stuck_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_n | input | 1 | Transmit enable from the controller, active low |
| tx_data | input | 1 | Transmit data bit from the controller |
| mode_normal | input | 1 | 1 = normal mode, 0 = standby |
| otemp | input | 1 | Overtemperature indication |
| vcc_ok | input | 1 | Core supply within range |
| vio_ok | input | 1 | I/O supply within range |
| drive_active | output | 1 | Driver switched active (0 = bus idle) |
| drive_data | output | 1 | Data level to drive while active |
| stuck_flag | output | 1 | Enable-stuck-low lockout in force |
| stuck_pulse | output | 1 | One-cycle event when the lockout begins |

## Verification
The timeout trip and the release of the enable can meet on the same edge. The timeout trip can also meet an idle-forcing condition such as overtemperature. Directed runs hold the enable low for exactly one sample fewer than the timeout and then release it, which must not trip. Other directed runs reach the full count while overtemperature is asserted, which must still trip, and then lower the enable again straight after a release, which must transmit at once. Random runs with long low stretches mixed with sporadic inhibits hit these meeting points repeatedly. A cycle-level reference model in the bench judges every output after every edge.

// File: rtl/txg_pkg.sv
package txg_pkg;

  // Reasons that force the bus idle regardless of the enable pin.
  typedef struct packed {
    logic standby;
    logic overheat;
    logic core_low;
    logic io_low;
  } txg_block_t;

  function automatic logic txg_any_block(txg_block_t b);
    return |b;
  endfunction

endpackage

// File: rtl/txg_rst_sync.sv
module txg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) chain_q <= '0;
        else           chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) chain_q <= '0;
        else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/txg_stuck_timer.sv
module txg_stuck_timer #(
  parameter longint unsigned LIMIT = 64'd40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_low,     // enable currently asserted
  output logic lock_next,  // lockout value after this edge
  output logic lock_q,
  output logic trip_q
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_d, trip_d;
  logic          cnt_en;

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    trip_d = 1'b0;
    if (!en_low) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (!lock_q) begin
      if (cnt_q == LAST) begin
        lock_d = 1'b1;
        trip_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  // the counter only moves while it can change
  assign cnt_en    = !en_low || !lock_q;
  assign lock_next = lock_d;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lock_q <= lock_d;
      trip_q <= trip_d;
    end
  end

  // R6: a released enable always ends the lockout
  p_release_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_low |=> !lock_q);

  // R5: the trip event never lasts two cycles
  p_trip_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> !trip_q);

  // R5: every lockout start carries the event
  p_trip_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> trip_q);

endmodule

// File: rtl/txg_inhibit.sv
module txg_inhibit
  import txg_pkg::*;
(
  input  logic mode_normal,
  input  logic otemp,
  input  logic vcc_ok,
  input  logic vio_ok,
  output logic blocked
);

  txg_block_t why;

  always_comb begin
    why.standby  = !mode_normal;
    why.overheat = otemp;
    why.core_low = !vcc_ok;
    why.io_low   = !vio_ok;
    blocked      = txg_any_block(why);
  end

endmodule

// File: rtl/txg_drive_stage.sv
module txg_drive_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic want,      // enable asserted and not locked out
  input  logic blocked,   // an idle-forcing condition is present
  input  logic tx_data,
  output logic drive_active,
  output logic drive_data
);

  logic act_d, dat_d;

  always_comb begin
    act_d = want && !blocked;
    dat_d = act_d && tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_active <= 1'b0;
      drive_data   <= 1'b0;
    end else begin
      drive_active <= act_d;
      drive_data   <= dat_d;
    end
  end

  // R7: any blocking condition idles the driver on the next cycle
  p_block_idles_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> !drive_active);

endmodule

// File: rtl/tx_gate_guard.sv
module tx_gate_guard #(
  parameter int unsigned CLK_HZ     = 80_000_000,
  parameter int unsigned TIMEOUT_US = 7700,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_n,
  input  logic tx_data,
  input  logic mode_normal,
  input  logic otemp,
  input  logic vcc_ok,
  input  logic vio_ok,
  output logic drive_active,
  output logic drive_data,
  output logic stuck_flag,
  output logic stuck_pulse
);

  localparam longint unsigned TIMEOUT_CYC =
    (64'(CLK_HZ) * 64'(TIMEOUT_US)) / 64'd1000000;
  localparam longint unsigned LIMIT = (TIMEOUT_CYC == 0) ? 64'd1 : TIMEOUT_CYC;

  logic rst_n_i;
  logic en_low;
  logic lock_next;
  logic blocked;

  assign en_low = !tx_en_n;

  txg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  txg_stuck_timer #(.LIMIT(LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .en_low    (en_low),
    .lock_next (lock_next),
    .lock_q    (stuck_flag),
    .trip_q    (stuck_pulse)
  );

  txg_inhibit u_inh (
    .mode_normal (mode_normal),
    .otemp       (otemp),
    .vcc_ok      (vcc_ok),
    .vio_ok      (vio_ok),
    .blocked     (blocked)
  );

  txg_drive_stage u_drv (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .want         (en_low && !lock_next),
    .blocked      (blocked),
    .tx_data      (tx_data),
    .drive_active (drive_active),
    .drive_data   (drive_data)
  );

  // R1: a high enable idles the driver one edge later
  p_enable_gate_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    tx_en_n |=> !drive_active);

  // R4: the driver is never active while locked out
  p_lock_idles_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    drive_active |-> !stuck_flag);

  // R5: the event only appears together with the lockout level
  p_pulse_in_lock_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    stuck_pulse |-> stuck_flag);

  // R8: supply loss idles the driver
  p_supply_idles_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!vcc_ok || !vio_ok) |=> !drive_active);

  // R9: standby idles the driver
  p_standby_idles_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    !mode_normal |=> !drive_active);

endmodule

// File: tb/tx_gate_guard_tb_top.sv
module tx_gate_guard_tb_top;

  localparam int unsigned CLK_HZ     = 10_000_000;
  localparam int unsigned TIMEOUT_US = 4;
  localparam int TO = (CLK_HZ / 1_000_000) * TIMEOUT_US;  // 40 samples

  logic clk = 1'b0;
  logic rst_n;
  logic tx_en_n, tx_data, mode_normal, otemp, vcc_ok, vio_ok;
  logic drive_active, drive_data, stuck_flag, stuck_pulse;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  int m_cnt  = 0;
  bit m_lock = 0;

  always #4 clk = ~clk;  // 125 MHz

  tx_gate_guard #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US)) dut_i (
    .clk (clk), .rst_n (rst_n), .tx_en_n (tx_en_n), .tx_data (tx_data),
    .mode_normal (mode_normal), .otemp (otemp), .vcc_ok (vcc_ok), .vio_ok (vio_ok),
    .drive_active (drive_active), .drive_data (drive_data),
    .stuck_flag (stuck_flag), .stuck_pulse (stuck_pulse)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_active(bit en_n, bit lock, bit mode, bit ot, bit vcc, bit vio);
    return !en_n && !lock && mode && !ot && vcc && vio;
  endfunction

  // apply one cycle of inputs, advance the model, check after the edge
  task automatic step(bit en_n, bit d, bit mode, bit ot, bit vcc, bit vio, string tag);
    bit e_act, e_dat, e_pulse;
    tx_en_n = en_n; tx_data = d; mode_normal = mode;
    otemp = ot; vcc_ok = vcc; vio_ok = vio;
    e_pulse = 0;
    if (en_n) begin
      m_cnt = 0; m_lock = 0;
    end else if (!m_lock) begin
      if (m_cnt == TO - 1) begin m_lock = 1; e_pulse = 1; end
      else m_cnt++;
    end
    e_act = exp_active(en_n, m_lock, mode, ot, vcc, vio);
    e_dat = e_act && d;
    @(posedge clk);
    @(negedge clk);
    check(tag, "drive_active", drive_active, e_act);
    check(tag, "drive_data",   drive_data,   e_dat);
    check(tag, "stuck_flag",   stuck_flag,   m_lock);
    check(tag, "stuck_pulse",  stuck_pulse,  e_pulse);
    if (!drive_active) check("R3", "drive_data when idle", drive_data, 1'b0);
  endtask

  task automatic tx(bit en_n, bit d, string tag);
    step(en_n, d, 1, 0, 1, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit en_n_r;
    void'($urandom(32'd20240611));
    rst_n = 0; tx_en_n = 1; tx_data = 0; mode_normal = 1;
    otemp = 0; vcc_ok = 1; vio_ok = 1;
    repeat (3) @(negedge clk);
    check("R11", "drive_active", drive_active, 1'b0);
    check("R11", "drive_data",   drive_data,   1'b0);
    check("R11", "stuck_flag",   stuck_flag,   1'b0);
    check("R11", "stuck_pulse",  stuck_pulse,  1'b0);
    rst_n = 1;
    repeat (4) tx(1, 1, "R1 idle after reset");

    // basic transmission with a data pattern
    tx(0, 1, "R2 data"); tx(0, 0, "R2 data"); tx(0, 1, "R2 data");
    tx(0, 1, "R2 data"); tx(0, 0, "R2 data");
    tx(1, 1, "R1 release");

    // run one sample short of the timeout, then release on the trip edge
    for (int i = 0; i < TO - 1; i++) tx(0, i[0], "R4 short run");
    tx(1, 0, "R4 release at limit");
    check("R4", "no trip on short run", stuck_flag, 1'b0);

    // full run trips
    for (int i = 0; i < TO; i++) tx(0, 1, "R4 full run");
    check("R4", "tripped", stuck_flag, 1'b1);
    for (int i = 0; i < 6; i++) tx(0, 1, "R6 held low");
    tx(1, 1, "R6 release clears");
    tx(0, 1, "R6 resume");
    check("R6", "resumed drive", drive_active, 1'b1);
    for (int i = 0; i < TO - 2; i++) tx(0, 0, "R6 fresh count");
    check("R6", "count restarted", stuck_flag, 1'b0);
    tx(1, 0, "R6 release");

    // idle-forcing conditions
    step(0, 1, 1, 1, 1, 1, "R7 overtemp");
    step(0, 1, 1, 0, 0, 1, "R8 core supply");
    step(0, 1, 1, 0, 1, 0, "R8 io supply");
    step(0, 1, 0, 0, 1, 1, "R9 standby");
    tx(0, 1, "R2 after inhibits");
    tx(1, 0, "R1 release");

    // watchdog keeps counting under overtemperature
    for (int i = 0; i < TO; i++) step(0, 1, 1, 1, 1, 1, "R10 trip under overtemp");
    check("R10", "tripped while blocked", stuck_flag, 1'b1);
    tx(0, 1, "R6 still locked");
    tx(1, 1, "R6 release");

    // random mix
    en_n_r = 1;
    for (int i = 0; i < 4000; i++) begin
      if (en_n_r) en_n_r = ($urandom_range(3) != 0);
      else        en_n_r = ($urandom_range(59) == 0);
      step(en_n_r, 1'($urandom_range(1)),
           ($urandom_range(29) != 0), ($urandom_range(39) == 0),
           ($urandom_range(49) != 0), ($urandom_range(49) != 0),
           "R2 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule